// File: doc/BRIEF.md
# I2C EEPROM Transfer Sequencer

This block drives a byte-level I2C engine to move the whole contents of a small serial EEPROM (up to 2 KiB) in one request. A single start pulse, a read/write select and the memory size are enough. The block then breaks the transfer into engine operations: device-select bytes, the low address byte and data bytes. Each operation carries a data byte and a four-bit flag field. The block waits for the engine's completion strobe and checks the acknowledge bit that comes back.

Reads take the whole memory in sequence. Addressing is set up again at the start of every 256-byte block, because the upper address bits travel inside the device-select byte. Bytes read are handed to a consumer over a valid/ready stream, and the next engine read is held back while that stream is full. Writes take bytes from a valid/ready stream and group them into 16-byte pages. Each page is closed with a stop and followed by a fixed programming wait. A byte flagged as last ends the write early; that byte also carries a stop and is followed by the wait.

Any acknowledge value other than the expected one aborts the transfer. The block issues a closing stop operation, sets a sticky error flag and returns to idle. The size input must be a power of two from 16 up to 2^ADDR_W bytes.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: After reset the block is idle: op_valid_o, busy_o, done_o, error_o and rd_valid_o are all 0.
- R2: A device-select byte is {4'hA, ext[2:0], rw}. ext is memory address bits [10:8] ANDed with the same bits of (size-1). rw is 1 for the read select and 0 for the write select.
- R3: For a read, at address 0 and at every address whose bits [7:0] are zero, three operations are issued in order: write-select with flags 4'h2, the low address byte with flags 4'h0, and read-select with flags 4'h2. Each of them must return ACK (op_nack_i = 0).
- R4: Every read byte except the last is requested with data 0 and flags 4'h9, where the master drives the acknowledge. The bytes returned on op_rdata_i come out on the read stream in address order.
- R5: The last byte of a read is requested with data 0 and flags 4'h5 (read plus stop), and it must return NACK (op_nack_i = 1). An ACK there is an error.
- R6: For a write, at address 0 and at every address whose bits [3:0] are zero, a write-select with flags 4'h2 is issued, followed by the low address byte with flags 4'h0, each expecting ACK.
- R7: Each write data byte is passed unchanged as op data. Its flags are 4'h4 (stop) when its address bits [3:0] are 4'hF, and 4'h0 otherwise. Every data byte must return ACK.
- R8: After a write data operation that carried a stop, no operation is issued, and done_o is not raised, for at least WAIT_CYC = CLK_KHZ*WAIT_US/1000 clock cycles.
- R9: A write byte taken with wr_last_i = 1, or the byte at address size-1, ends the write. It is sent with flags 4'h4, followed by the programming wait, and then by done_o.
- R10: An unexpected acknowledge value makes the block issue one operation with data 0 and flags 4'h5, set error_o, return to idle without done_o, and keep error_o at 1 while idle.
- R11: A read data operation with flags 4'h9 is never issued while rd_valid_o is 1; the block waits for the consumer to take the byte first.
- R12: Once op_valid_o is raised, it stays high with op_data_o and op_flags_o unchanged until the cycle in which op_done_i is seen.
- R13: A successful transfer ends with done_o high for exactly one cycle and error_o at 0. A new start clears error_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| write_mode_i | input | 1 | 1 = write transfer, 0 = read transfer |
| size_i | input | ADDR_W+1 | Memory size in bytes (power of two) |
| wr_data_i | input | 8 | Write stream data |
| wr_last_i | input | 1 | Write stream byte is the last one |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | 8 | Read stream data |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| op_valid_o | output | 1 | Engine operation pending |
| op_data_o | output | 8 | Engine operation data byte |
| op_flags_o | output | 4 | bit0 read, bit1 start, bit2 stop, bit3 drive acknowledge |
| op_done_i | input | 1 | Engine completion strobe |
| op_nack_i | input | 1 | Returned acknowledge bit, 1 = NACK, valid with op_done_i |
| op_rdata_i | input | 8 | Byte read by the engine, valid with op_done_i |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | Sticky acknowledge error flag |

## Verification
A wrong step or address counter shows up at once in the operation log. A select byte appears at the wrong index, the low address byte differs, or the wrong extension bits are sent. The stream of read bytes also shifts by one for every lost or repeated operation. A wrong expected-acknowledge state shows within one operation: the transfer either aborts with error_o when it should not, or runs past an injected fault. A short programming wait, or a missing one, shows as a gap smaller than WAIT_CYC between a stop-carrying write and the next operation.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NEXT,
        S_OP,
        S_PROG,
        S_ABORT,
        S_FIN
    } state_t;

    typedef enum logic [1:0] {
        STEP_SELW,
        STEP_LOW,
        STEP_SELR,
        STEP_DATA
    } step_t;

    localparam logic [3:0] FL_READ  = 4'h1;
    localparam logic [3:0] FL_START = 4'h2;
    localparam logic [3:0] FL_STOP  = 4'h4;
    localparam logic [3:0] FL_DACK  = 4'h8;

    localparam logic [3:0] DEV_HI_NIBBLE = 4'hA;
    localparam int         EXT_BITS      = 3;

endpackage

// File: rtl/eeprom_seq_addr.sv
module eeprom_seq_addr
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W:0]   size_i,
    output logic [7:0]        sel_w_o,
    output logic [7:0]        sel_r_o,
    output logic              last_o,
    output logic              page_end_o
);

    localparam int EXT_W = ADDR_W - 8;

    logic [ADDR_W:0]     mask;
    logic [EXT_BITS-1:0] ext;

    assign mask = size_i - 1'b1;

    // upper address bits that the memory size actually uses go into the select byte
    for (genvar i = 0; i < EXT_BITS; i++) begin : g_ext
        if (i < EXT_W) begin : g_used
            assign ext[i] = addr_i[8+i] & mask[8+i];
        end else begin : g_pad
            assign ext[i] = 1'b0;
        end
    end

    assign sel_w_o    = {DEV_HI_NIBBLE, ext, 1'b0};
    assign sel_r_o    = {DEV_HI_NIBBLE, ext, 1'b1};
    assign last_o     = ({1'b0, addr_i} == mask);
    assign page_end_o = (addr_i[3:0] == 4'hF);

endmodule

// File: rtl/eeprom_seq_wait.sv
module eeprom_seq_wait #(
    parameter int WAIT_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(WAIT_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_WAIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o); // R8

    AST_WAIT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !busy_o) |=> !busy_o); // R8

endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int CLK_KHZ = 50000,
    parameter int WAIT_US = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_mode_i,
    input  logic [ADDR_W:0]   size_i,
    input  logic [7:0]        wr_data_i,
    input  logic              wr_last_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic              op_valid_o,
    output logic [7:0]        op_data_o,
    output logic [3:0]        op_flags_o,
    input  logic              op_done_i,
    input  logic              op_nack_i,
    input  logic [7:0]        op_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);

    localparam int WAIT_CYC = CLK_KHZ * WAIT_US / 1000;

    typedef struct packed {
        state_t          st;
        step_t           step;
        logic            wr;
        logic [ADDR_W:0] size;
        logic [ADDR_W:0] addr;
        logic [7:0]      odata;
        logic [3:0]      oflags;
        logic            exp_nack;
        logic            op_stop;
        logic            ended;
        logic [7:0]      rdata;
        logic            rvalid;
        logic            done;
        logic            err;
    } regs_t;

    regs_t d, q;

    logic [7:0]      sel_w, sel_r;
    logic            at_last, page_end;
    logic            wait_load, wait_busy;
    logic [ADDR_W:0] addr_inc;

    eeprom_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .addr_i     (q.addr[ADDR_W-1:0]),
        .size_i     (q.size),
        .sel_w_o    (sel_w),
        .sel_r_o    (sel_r),
        .last_o     (at_last),
        .page_end_o (page_end)
    );

    eeprom_seq_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wait_load),
        .busy_o (wait_busy)
    );

    assign addr_inc = q.addr + 1'b1;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        wait_load = 1'b0;

        if (q.rvalid && rd_ready_i) begin
            d.rvalid = 1'b0;
        end

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.wr    = write_mode_i;
                    d.size  = size_i;
                    d.addr  = '0;
                    d.step  = STEP_SELW;
                    d.ended = 1'b0;
                    d.err   = 1'b0;
                    d.st    = S_NEXT;
                end
            end

            S_NEXT: begin
                case (q.step)
                    STEP_SELW: begin
                        d.odata    = sel_w;
                        d.oflags   = FL_START;
                        d.exp_nack = 1'b0;
                        d.st       = S_OP;
                    end
                    STEP_LOW: begin
                        d.odata    = q.addr[7:0];
                        d.oflags   = 4'h0;
                        d.exp_nack = 1'b0;
                        d.st       = S_OP;
                    end
                    STEP_SELR: begin
                        d.odata    = sel_r;
                        d.oflags   = FL_START;
                        d.exp_nack = 1'b0;
                        d.st       = S_OP;
                    end
                    default: begin
                        if (q.wr) begin
                            if (wr_valid_i) begin
                                d.odata    = wr_data_i;
                                d.op_stop  = page_end || wr_last_i || at_last;
                                d.ended    = wr_last_i || at_last;
                                d.oflags   = (page_end || wr_last_i || at_last) ? FL_STOP : 4'h0;
                                d.exp_nack = 1'b0;
                                d.st       = S_OP;
                            end
                        end else if (!q.rvalid) begin
                            d.odata    = 8'h00;
                            d.oflags   = at_last ? (FL_READ | FL_STOP) : (FL_READ | FL_DACK);
                            d.exp_nack = at_last;
                            d.st       = S_OP;
                        end
                    end
                endcase
            end

            S_OP: begin
                if (op_done_i) begin
                    if (op_nack_i != q.exp_nack) begin
                        d.err    = 1'b1;
                        d.odata  = 8'h00;
                        d.oflags = FL_READ | FL_STOP;
                        d.st     = S_ABORT;
                    end else begin
                        case (q.step)
                            STEP_SELW: begin
                                d.step = STEP_LOW;
                                d.st   = S_NEXT;
                            end
                            STEP_LOW: begin
                                d.step = q.wr ? STEP_DATA : STEP_SELR;
                                d.st   = S_NEXT;
                            end
                            STEP_SELR: begin
                                d.step = STEP_DATA;
                                d.st   = S_NEXT;
                            end
                            default: begin
                                d.addr = addr_inc;
                                if (q.wr) begin
                                    if (q.op_stop) begin
                                        wait_load = 1'b1;
                                        d.step    = STEP_SELW;
                                        d.st      = S_PROG;
                                    end else begin
                                        d.st = S_NEXT;
                                    end
                                end else begin
                                    d.rdata  = op_rdata_i;
                                    d.rvalid = 1'b1;
                                    if (at_last) begin
                                        d.st = S_FIN;
                                    end else begin
                                        d.step = (addr_inc[7:0] == 8'h00) ? STEP_SELW : STEP_DATA;
                                        d.st   = S_NEXT;
                                    end
                                end
                            end
                        endcase
                    end
                end
            end

            S_PROG: begin
                if (!wait_busy) begin
                    d.st = q.ended ? S_FIN : S_NEXT;
                end
            end

            S_ABORT: begin
                if (op_done_i) begin
                    d.st = S_IDLE;
                end
            end

            S_FIN: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end

            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign op_valid_o = (q.st == S_OP) || (q.st == S_ABORT);
    assign op_data_o  = q.odata;
    assign op_flags_o = q.oflags;
    assign wr_ready_o = (q.st == S_NEXT) && (q.step == STEP_DATA) && q.wr;
    assign rd_data_o  = q.rdata;
    assign rd_valid_o = q.rvalid;
    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign error_o    = q.err;

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_done_i) |=> (op_valid_o && $stable(op_data_o) && $stable(op_flags_o))); // R12

    AST_SEL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(op_valid_o) && op_flags_o[1]) |-> (op_data_o[7:4] == 4'hA)); // R2

    AST_RD_ISSUE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(op_valid_o) && op_flags_o[3]) |-> !rd_valid_o); // R11

    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_busy |-> (!op_valid_o && !done_o)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !error_o); // R13

endmodule

// File: tb/eeprom_xfer_seq_test.sv
module eeprom_xfer_seq_test;

    localparam int AW       = 11;
    localparam int CLK_KHZ  = 50;
    localparam int WAIT_US  = 5000;
    localparam int WAIT_CYC = CLK_KHZ * WAIT_US / 1000;
    localparam int LOG_N    = 4096;
    localparam int WD_LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          write_mode_i = 1'b0;
    logic [AW:0]   size_i = '0;
    logic [7:0]    wr_data_i = '0;
    logic          wr_last_i = 1'b0;
    logic          wr_valid_i = 1'b0;
    logic          wr_ready_o;
    logic [7:0]    rd_data_o;
    logic          rd_valid_o;
    logic          rd_ready_i = 1'b0;
    logic          op_valid_o;
    logic [7:0]    op_data_o;
    logic [3:0]    op_flags_o;
    logic          op_done_i = 1'b0;
    logic          op_nack_i = 1'b0;
    logic [7:0]    op_rdata_i = '0;
    logic          busy_o, done_o, error_o;

    always #10 clk = ~clk;

    eeprom_xfer_seq #(.ADDR_W(AW), .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_mode_i(write_mode_i),
        .size_i(size_i), .wr_data_i(wr_data_i), .wr_last_i(wr_last_i),
        .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .op_valid_o(op_valid_o),
        .op_data_o(op_data_o), .op_flags_o(op_flags_o), .op_done_i(op_done_i),
        .op_nack_i(op_nack_i), .op_rdata_i(op_rdata_i), .busy_o(busy_o),
        .done_o(done_o), .error_o(error_o)
    );

    int checks = 0;
    int fails  = 0;

    // control written only by the main block
    logic       clear_req = 1'b0;
    int         fault_op  = -1;
    int         wlen      = 0;
    logic       use_last  = 1'b0;
    logic [7:0] wmem [0:2047];
    logic [7:0] ex_data  [0:LOG_N-1];
    logic [3:0] ex_flags [0:LOG_N-1];
    int         n_exp;

    // observations written only by the model block
    logic [7:0] lg_data  [0:LOG_N-1];
    logic [3:0] lg_flags [0:LOG_N-1];
    int         lg_cyc   [0:LOG_N-1];
    int         lg_dcyc  [0:LOG_N-1];
    logic [7:0] rx       [0:2047];
    int         n_ops, n_rx, rd_cnt, widx, stab_viol, bp_viol, cyc;

    function automatic logic [7:0] mem_byte(int k);
        return 8'((k * 37 + 91) ^ (k >> 3));
    endfunction

    function automatic logic [7:0] sel_byte(int a, int size, int rw);
        return 8'(8'hA0 | ((((a >> 8) & ((size - 1) >> 8) & 7)) << 1) | rw);
    endfunction

    // engine, consumer, producer and watchdog, all on the falling edge
    initial begin
        int  e_cnt;
        bit  e_busy, acc_pend, nk;
        logic [7:0] e_d;
        logic [3:0] e_f;
        e_cnt = 0; e_busy = 0; acc_pend = 0; e_d = '0; e_f = '0;
        n_ops = 0; n_rx = 0; rd_cnt = 0; widx = 0; stab_viol = 0; bp_viol = 0; cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                $display("FAIL watchdog expired: act=%0d exp<=%0d cycles", cyc, WD_LIMIT);
                $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
                $finish;
            end
            if (clear_req) begin
                n_ops = 0; n_rx = 0; rd_cnt = 0; widx = 0; stab_viol = 0; bp_viol = 0;
                acc_pend = 0; e_busy = 0; op_done_i = 1'b0; wr_valid_i = 1'b0; wr_last_i = 1'b0;
            end else begin
                // engine model
                if (op_done_i) begin
                    op_done_i = 1'b0;
                end else if (!e_busy && op_valid_o) begin
                    if (n_ops < LOG_N) begin
                        lg_data[n_ops]  = op_data_o;
                        lg_flags[n_ops] = op_flags_o;
                        lg_cyc[n_ops]   = cyc;
                    end
                    if (op_flags_o == 4'h9 && rd_valid_o) bp_viol++;
                    n_ops++;
                    e_busy = 1; e_cnt = 1 + int'($urandom % 4); e_d = op_data_o; e_f = op_flags_o;
                end else if (e_busy) begin
                    if (!op_valid_o || op_data_o != e_d || op_flags_o != e_f) stab_viol++;
                    e_cnt--;
                    if (e_cnt == 0) begin
                        nk = (e_f == 4'h5);
                        if (n_ops - 1 == fault_op) nk = !nk;
                        op_nack_i = nk;
                        op_rdata_i = e_f[0] ? mem_byte(rd_cnt) : 8'h00;
                        if (e_f[0]) rd_cnt++;
                        if (n_ops - 1 < LOG_N) lg_dcyc[n_ops-1] = cyc;
                        op_done_i = 1'b1;
                        e_busy = 0;
                    end
                end
                // consumer
                rd_ready_i = ($urandom % 4) != 0;
                if (rd_valid_o && rd_ready_i) begin
                    if (n_rx < 2048) rx[n_rx] = rd_data_o;
                    n_rx++;
                end
                // producer
                if (acc_pend) widx++;
                wr_valid_i = (widx < wlen) && (($urandom % 5) != 0);
                wr_data_i  = wmem[widx % 2048];
                wr_last_i  = use_last && (widx == wlen - 1);
                acc_pend   = wr_valid_i && wr_ready_o;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input bit wr, input int size, input int len);
        n_exp = 0;
        if (!wr) begin
            for (int a = 0; a < size; a++) begin
                if ((a & 255) == 0) begin
                    ex_data[n_exp] = sel_byte(a, size, 0); ex_flags[n_exp] = 4'h2; n_exp++;
                    ex_data[n_exp] = 8'(a);                ex_flags[n_exp] = 4'h0; n_exp++;
                    ex_data[n_exp] = sel_byte(a, size, 1); ex_flags[n_exp] = 4'h2; n_exp++;
                end
                ex_data[n_exp] = 8'h00; ex_flags[n_exp] = (a == size - 1) ? 4'h5 : 4'h9; n_exp++;
            end
        end else begin
            for (int a = 0; a < len; a++) begin
                if ((a & 15) == 0) begin
                    ex_data[n_exp] = sel_byte(a, size, 0); ex_flags[n_exp] = 4'h2; n_exp++;
                    ex_data[n_exp] = 8'(a);                ex_flags[n_exp] = 4'h0; n_exp++;
                end
                ex_data[n_exp]  = wmem[a];
                ex_flags[n_exp] = ((a & 15) == 15 || a == len - 1) ? 4'h4 : 4'h0;
                n_exp++;
            end
        end
    endtask

    task automatic run_xfer(input bit wr, input int size, input int len, input bit last_f,
                            input int fault, output bit got_done, output bit got_err,
                            output int done_cyc, output bit err_after_start);
        int t;
        clear_req = 1'b1;
        fault_op  = fault;
        wlen      = wr ? len : 0;
        use_last  = last_f;
        repeat (2) @(negedge clk);
        clear_req = 1'b0;
        write_mode_i = wr;
        size_i  = (AW+1)'(size);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        err_after_start = error_o;
        got_done = 0; got_err = 0; done_cyc = 0; t = 0;
        while (!got_done && !got_err && t < 60000) begin
            @(negedge clk);
            t++;
            if (done_o) begin
                got_done = 1; done_cyc = cyc;
            end else if (!busy_o && error_o) begin
                got_err = 1;
            end
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic cmp_ops(input string req);
        int bad;
        bad = 0;
        chk(n_ops == n_exp, req, "operation count", n_ops, n_exp);
        for (int i = 0; i < n_exp && i < n_ops; i++) begin
            if (lg_data[i] != ex_data[i] || lg_flags[i] != ex_flags[i]) begin
                bad++;
                if (bad <= 4)
                    chk(0, req, $sformatf("op %0d {data,flags}", i),
                        {lg_data[i], lg_flags[i]}, {ex_data[i], ex_flags[i]});
            end
        end
        chk(bad == 0, req, "mismatching operations", bad, 0);
    endtask

    task automatic cmp_rx(input int size);
        int bad;
        bad = 0;
        chk(n_rx == size, "R4", "read stream length", n_rx, size);
        for (int i = 0; i < size && i < n_rx; i++)
            if (rx[i] != mem_byte(i)) bad++;
        chk(bad == 0, "R4", "read stream bytes out of order", bad, 0);
    endtask

    task automatic chk_gaps(input int done_cyc);
        int bad;
        bad = 0;
        for (int i = 0; i + 1 < n_ops && i + 1 < LOG_N; i++)
            if (lg_flags[i] == 4'h4 && (lg_cyc[i+1] - lg_dcyc[i]) < WAIT_CYC) bad++;
        chk(bad == 0, "R8", "short programming gaps", bad, 0);
        if (n_ops > 0)
            chk((done_cyc - lg_dcyc[n_ops-1]) >= WAIT_CYC, "R9", "wait before done",
                done_cyc - lg_dcyc[n_ops-1], WAIT_CYC);
    endtask

    initial begin
        bit gd, ge, eas;
        int dc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) wmem[i] = 8'($urandom);

        repeat (4) @(negedge clk);
        chk(op_valid_o == 1'b0, "R1", "op_valid in reset", op_valid_o, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done in reset", {busy_o, done_o}, 0);
        chk(error_o == 1'b0 && rd_valid_o == 1'b0, "R1", "error/rd_valid in reset", {error_o, rd_valid_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && op_valid_o == 1'b0, "R1", "idle after reset", {busy_o, op_valid_o}, 0);

        // small read, random back-pressure
        build_exp(0, 32, 0);
        run_xfer(0, 32, 0, 0, -1, gd, ge, dc, eas);
        cmp_ops("R3");
        cmp_rx(32);
        chk(gd && !ge, "R13", "read 32 completes cleanly", {gd, ge}, 2'b10);
        chk(n_ops > 0 && lg_flags[n_ops-1] == 4'h5, "R5", "last read flags", lg_flags[n_ops-1], 4'h5);
        chk(bp_viol == 0, "R11", "reads issued while stream full", bp_viol, 0);
        chk(stab_viol == 0, "R12", "op changed while pending", stab_viol, 0);

        // read crossing 256-byte blocks
        build_exp(0, 512, 0);
        run_xfer(0, 512, 0, 0, -1, gd, ge, dc, eas);
        cmp_ops("R3");
        cmp_rx(512);
        chk(lg_data[259] == 8'hA2 && lg_data[261] == 8'hA3, "R2", "block 1 selects",
            {lg_data[259], lg_data[261]}, 16'hA2A3);
        chk(gd && !ge, "R13", "read 512 completes", {gd, ge}, 2'b10);

        // full 2 KiB read, all three extension bits
        build_exp(0, 2048, 0);
        run_xfer(0, 2048, 0, 0, -1, gd, ge, dc, eas);
        cmp_ops("R2");
        cmp_rx(2048);
        chk(lg_data[1813] == 8'hAE && lg_data[1815] == 8'hAF, "R2", "block 7 selects",
            {lg_data[1813], lg_data[1815]}, 16'hAEAF);
        chk(lg_data[1814] == 8'h00 && lg_flags[1814] == 4'h0, "R3", "block 7 low address",
            {lg_data[1814], lg_flags[1814]}, 12'h000);
        chk(bp_viol == 0 && stab_viol == 0, "R11", "handshake violations", bp_viol + stab_viol, 0);

        // full write of 64 bytes, four pages
        for (int i = 0; i < 2048; i++) wmem[i] = 8'($urandom);
        build_exp(1, 64, 64);
        run_xfer(1, 64, 64, 0, -1, gd, ge, dc, eas);
        cmp_ops("R6");
        chk(lg_flags[17] == 4'h4 && lg_flags[16] == 4'h0, "R7", "page end byte flags",
            {lg_flags[16], lg_flags[17]}, 8'h04);
        chk_gaps(dc);
        chk(gd && !ge, "R13", "write 64 completes", {gd, ge}, 2'b10);
        chk(stab_viol == 0, "R12", "write op stability", stab_viol, 0);

        // partial write ended by the last marker, crosses a 256 boundary
        for (int i = 0; i < 2048; i++) wmem[i] = 8'($urandom);
        build_exp(1, 1024, 300);
        run_xfer(1, 1024, 300, 1, -1, gd, ge, dc, eas);
        cmp_ops("R9");
        chk(n_ops > 0 && lg_flags[n_ops-1] == 4'h4 && lg_data[n_ops-1] == wmem[299], "R9",
            "early last byte", {lg_data[n_ops-1], lg_flags[n_ops-1]}, {wmem[299], 4'h4});
        chk_gaps(dc);
        chk(gd && !ge, "R9", "partial write completes", {gd, ge}, 2'b10);

        // NACK on the low address byte of a read
        build_exp(0, 32, 0);
        run_xfer(0, 32, 0, 0, 1, gd, ge, dc, eas);
        chk(ge && !gd, "R10", "abort on address NACK", {gd, ge}, 2'b01);
        chk(n_ops == 3, "R10", "ops up to abort", n_ops, 3);
        chk(lg_flags[2] == 4'h5 && lg_data[2] == 8'h00, "R10", "abort stop op",
            {lg_data[2], lg_flags[2]}, 12'h005);
        chk(error_o == 1'b1 && busy_o == 1'b0, "R10", "sticky error while idle", {error_o, busy_o}, 2'b10);

        // ACK on the last read byte must be an error; start clears old error
        run_xfer(0, 32, 0, 0, 34, gd, ge, dc, eas);
        chk(eas == 1'b0, "R13", "start clears error", eas, 0);
        chk(ge && !gd, "R5", "ACK on last read aborts", {gd, ge}, 2'b01);
        chk(n_ops == 36 && lg_flags[35] == 4'h5, "R5", "abort after last read", n_ops, 36);

        // NACK on the first write data byte
        build_exp(1, 32, 32);
        run_xfer(1, 32, 32, 0, 2, gd, ge, dc, eas);
        chk(ge && !gd, "R10", "abort on data NACK", {gd, ge}, 2'b01);
        chk(n_ops == 4 && lg_flags[3] == 4'h5, "R10", "abort op after data byte", n_ops, 4);
        chk(lg_data[2] == wmem[0] && lg_flags[2] == 4'h0, "R7", "first data byte passed",
            {lg_data[2], lg_flags[2]}, {wmem[0], 4'h0});

        // clean short read after errors
        build_exp(0, 16, 0);
        run_xfer(0, 16, 0, 0, -1, gd, ge, dc, eas);
        cmp_ops("R4");
        cmp_rx(16);
        chk(gd && !ge && error_o == 1'b0, "R13", "recovery read", {gd, ge, error_o}, 3'b100);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule